// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial memory front end and a 2048-by-8 storage array. While a write transaction is open it gathers the data bytes into a 16-entry page buffer. The buffer is addressed by the low four bits of the running address. The upper seven bits select the page and stay fixed for the whole transaction. When the front end reports a STOP condition, the block runs a self-timed commit. It holds a busy flag for a fixed number of clock cycles. During the first sixteen cycles of that window it drives the array write port, once for each buffer entry loaded in the transaction.

The busy flag tells the front end to stop acknowledging its address. While it is high the block ignores every input strobe. A hardware protect input guards the upper half of the array. If the page lies in that half while the input is high, the commit is dropped and no busy window follows.

If a transaction carries no data, a STOP starts nothing. If a repeated START ends the transaction instead of a STOP, the buffered bytes are discarded.

Top module: `page_commit_buf`

## Requirements
- R1: Byte k of a transaction (k counted from 0) goes to array address {page, (start offset + k) mod 16}. The page is begin_addr[10:4] and the start offset is begin_addr[3:0].
- R2: A commit_stb that launches a commit raises busy in the cycle after the strobe. Busy stays high for exactly WR_CYCLES cycles.
- R3: mem_we is high only while busy is high. There is one write per loaded entry, issued in ascending offset order.
- R4: When wp=1 at the commit strobe and begin_addr[10]=1, there is no write and no busy window.
- R5: When wp=1 and the page is in the lower half (bit 10 = 0), the commit proceeds. When wp=0, pages in the upper half are written.
- R6: After more than 16 bytes, each offset holds the last byte sent to it, and exactly 16 writes are issued.
- R7: Only entries loaded since the most recent wr_begin are written. Each wr_begin clears the loaded mask.
- R8: A commit_stb with no bytes loaded raises no busy and issues no write.
- R9: restart_stb discards the loaded bytes, so a later commit_stb starts nothing.
- R10: While busy is high, wr_begin, byte_stb, commit_stb and restart_stb have no effect.
- R11: After reset, busy=0 and mem_we=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_begin | input | 1 | Opens a write transaction at begin_addr |
| begin_addr | input | 11 | Start address of the transaction |
| byte_stb | input | 1 | One data byte is present |
| byte_data | input | 8 | Data byte |
| commit_stb | input | 1 | STOP seen: request commit |
| restart_stb | input | 1 | Repeated START ended the transaction: discard |
| wp | input | 1 | Protects the upper half of the array when high |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit window active |

## Verification
The bench overrides WR_CYCLES to 24. This keeps the full busy window short enough to count cycle by cycle, while leaving eight idle cycles after the sixteen write slots. Those spare cycles are where late write pulses would show up. Address and data widths stay at their defaults, so the 16-entry page, the offset wrap and the protected upper half all behave as in the full-size block. A shadow array in the bench records every write, so each commit can be checked for its addresses, its data, its order and its count.

// File: rtl/pcb_pkg.sv
// Shared types for the page commit buffer.
package pcb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } pcb_state_e;
endpackage

// File: rtl/pcb_page_store.sv
// Page buffer: one data register and one loaded bit per page offset.
// Assumes the caller never asserts load_base and put in the same cycle.
// clr has priority over everything else.
module pcb_page_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_base,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic                     put,
    input  logic [DATA_W-1:0]        put_data,
    input  logic                     clr,
    input  logic [PAGE_W-1:0]        rd_slot,
    output logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic                     any_loaded,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_loaded
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] ptr;
    logic [PAGE_N-1:0] loaded;
    logic [DATA_W-1:0] entry [PAGE_N];

    // Page number and write pointer: set at transaction start, pointer steps per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_base <= '0;
            ptr       <= '0;
        end else if (load_base) begin
            page_base <= base_addr[ADDR_W-1:PAGE_W];
            ptr       <= base_addr[PAGE_W-1:0];
        end else if (put) begin
            ptr       <= ptr + 1'b1;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < PAGE_N; gi++) begin : g_entry
            // Loaded bit for this offset: cleared on clr or a new transaction.
            always_ff @(posedge clk) begin
                if (!rst_n || clr || load_base)
                    loaded[gi] <= 1'b0;
                else if (put && ptr == PAGE_W'(gi))
                    loaded[gi] <= 1'b1;
            end

            // Data register for this offset: the latest byte wins.
            always_ff @(posedge clk) begin
                if (put && !load_base && ptr == PAGE_W'(gi))
                    entry[gi] <= put_data;
            end
        end
    endgenerate

    // Read side used by the commit sequencer.
    always_comb begin
        any_loaded = |loaded;
        rd_data    = entry[rd_slot];
        rd_loaded  = loaded[rd_slot];
    end
endmodule

// File: rtl/pcb_commit_timer.sv
// Commit window timer: on launch, holds busy for WR_CYCLES cycles.
// The first 2**PAGE_W cycles of the window are write slots.
// Assumes WR_CYCLES >= 2**PAGE_W. Launch is ignored while busy.
module pcb_commit_timer
    import pcb_pkg::*;
#(
    parameter int WR_CYCLES = 1000,
    parameter int PAGE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    output logic              busy,
    output logic [PAGE_W-1:0] slot,
    output logic              slot_live,
    output logic              done
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);

    pcb_state_e       state;
    logic [CNT_W-1:0] cnt;

    // Window state and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (launch) begin
                    state <= ST_BUSY;
                    cnt   <= '0;
                end
                ST_BUSY: if (done) begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt   <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Slot decode for the write port.
    always_comb begin
        busy      = (state == ST_BUSY);
        done      = busy && (cnt == CNT_W'(WR_CYCLES - 1));
        slot      = cnt[PAGE_W-1:0];
        slot_live = busy && (cnt < CNT_W'(PAGE_N));
    end
endmodule

// File: rtl/page_commit_buf.sv
// Page write buffer with a self-timed commit window and upper-half protect.
// Assumes the front end marks each data byte with byte_stb and reports
// STOP on commit_stb and a repeated START on restart_stb.
// All strobes are ignored while busy is high.
module page_commit_buf #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 4,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_begin,
    input  logic [ADDR_W-1:0] begin_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit_stb,
    input  logic              restart_stb,
    input  logic              wp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic              open_ok, put_ok, stop_ok, restart_ok;
    logic              launch, clr, done, slot_live, rd_loaded, any_loaded;
    logic [PAGE_W-1:0] slot;
    logic [BASE_W-1:0] page_base;
    logic [DATA_W-1:0] rd_data;
    logic              guarded;

    // Gate the front-end strobes while a commit window runs.
    always_comb begin
        open_ok    = wr_begin    && !busy;
        put_ok     = byte_stb    && !busy && !wr_begin;
        stop_ok    = commit_stb  && !busy;
        restart_ok = restart_stb && !busy;
        guarded    = wp && page_base[BASE_W-1];
        launch     = stop_ok && any_loaded && !guarded;
        clr        = restart_ok || (stop_ok && !launch) || done;
    end

    pcb_page_store #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_base  (open_ok),
        .base_addr  (begin_addr),
        .put        (put_ok),
        .put_data   (byte_data),
        .clr        (clr),
        .rd_slot    (slot),
        .page_base  (page_base),
        .any_loaded (any_loaded),
        .rd_data    (rd_data),
        .rd_loaded  (rd_loaded)
    );

    pcb_commit_timer #(
        .WR_CYCLES (WR_CYCLES),
        .PAGE_W    (PAGE_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .busy      (busy),
        .slot      (slot),
        .slot_live (slot_live),
        .done      (done)
    );

    // Array write port driven from the current slot.
    always_comb begin
        mem_we    = slot_live && rd_loaded;
        mem_addr  = {page_base, slot};
        mem_wdata = rd_data;
    end
endmodule

// File: rtl/pcb_checker.sv
// Temporal checks on page_commit_buf, attached with bind.
module pcb_checker #(
    parameter int ADDR_W    = 11,
    parameter int WR_CYCLES = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit_stb,
    input logic              wp,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    logic [31:0] blen;

    // Count the busy cycles already elapsed in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)    blen <= '0;
        else if (busy) blen <= blen + 1;
        else           blen <= '0;
    end

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R3
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit_stb)); // R2
    AST_BUSY_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blen < WR_CYCLES)); // R2
    AST_BUSY_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(blen) == WR_CYCLES - 1)); // R2
    AST_PROTECT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !($past(wp) && mem_addr[ADDR_W-1])); // R4
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:4])); // R10
endmodule

bind page_commit_buf pcb_checker #(
    .ADDR_W    (ADDR_W),
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_stb (commit_stb),
    .wp         (wp),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr)
);

// File: tb/sim_page_commit_buf.sv
module sim_page_commit_buf;
    localparam int WRC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_begin = 1'b0, byte_stb = 1'b0, commit_stb = 1'b0;
    logic        restart_stb = 1'b0, wp = 1'b0;
    logic [10:0] begin_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        mem_we, busy;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  shadow [2048];
    logic        hit    [2048];
    int          wr_cnt = 0;
    logic [10:0] prev_addr = '0;
    int          order_err = 0;

    always #2.5 clk = ~clk;

    page_commit_buf #(.WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .begin_addr(begin_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .commit_stb(commit_stb),
        .restart_stb(restart_stb), .wp(wp), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy)
    );

    // Record array writes away from the active edge.
    always @(negedge clk) begin
        if (mem_we) begin
            if (wr_cnt > 0 && mem_addr <= prev_addr) order_err++;
            shadow[mem_addr] = mem_wdata;
            hit[mem_addr]    = 1'b1;
            prev_addr        = mem_addr;
            wr_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < 2048; i++) hit[i] = 1'b0;
        wr_cnt = 0;
        order_err = 0;
    endtask

    task automatic open_wr(input logic [10:0] a);
        @(negedge clk); wr_begin = 1'b1; begin_addr = a;
        @(negedge clk); wr_begin = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_data = d;
        @(negedge clk); byte_stb = 1'b0;
    endtask

    // Pulse commit and count the busy cycles that follow.
    task automatic commit(output int bc);
        @(negedge clk); commit_stb = 1'b1;
        @(negedge clk); commit_stb = 1'b0;
        bc = 0;
        repeat (WRC + 4) begin
            if (busy) bc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R11 busy", busy, 0);
        check(mem_we == 1'b0, "R11 mem_we", mem_we, 0);
    endtask

    task automatic t_basic();
        int bc;
        clear_log();
        open_wr(11'h123);
        for (int k = 0; k < 5; k++) put(8'hA0 + 8'(k));
        commit(bc);
        check(bc == WRC, "R2 busy length", bc, WRC);
        check(wr_cnt == 5, "R3 write count", wr_cnt, 5);
        check(order_err == 0, "R3 ascending order", order_err, 0);
        for (int k = 0; k < 5; k++)
            check(hit[11'h123 + k] && shadow[11'h123 + k] == 8'hA0 + 8'(k),
                  "R1 placement", shadow[11'h123 + k], 8'hA0 + k);
    endtask

    task automatic t_wrap();
        int bc;
        logic [10:0] exp_a [4];
        exp_a[0] = 11'h05E; exp_a[1] = 11'h05F; exp_a[2] = 11'h050; exp_a[3] = 11'h051;
        clear_log();
        open_wr(11'h05E);
        for (int k = 0; k < 4; k++) put(8'h30 + 8'(k));
        commit(bc);
        check(wr_cnt == 4, "R1 wrap count", wr_cnt, 4);
        check(hit[11'h060] == 1'b0, "R1 no page carry", hit[11'h060], 0);
        for (int k = 0; k < 4; k++)
            check(hit[exp_a[k]] && shadow[exp_a[k]] == 8'h30 + 8'(k),
                  "R1 wrap data", shadow[exp_a[k]], 8'h30 + k);
    endtask

    task automatic t_overflow();
        int bc;
        clear_log();
        open_wr(11'h200);
        for (int k = 0; k < 20; k++) put(8'(k));
        commit(bc);
        check(wr_cnt == 16, "R6 count", wr_cnt, 16);
        for (int j = 0; j < 16; j++) begin
            int e;
            e = (j < 4) ? j + 16 : j;
            check(shadow[11'h200 + j] == 8'(e), "R6 last wins", shadow[11'h200 + j], e);
        end
    endtask

    task automatic t_wp();
        int bc;
        clear_log();
        wp = 1'b1;
        open_wr(11'h400); put(8'h11); put(8'h22);
        commit(bc);
        check(bc == 0, "R4 no busy", bc, 0);
        check(wr_cnt == 0, "R4 no write", wr_cnt, 0);
        clear_log();
        open_wr(11'h3F0); put(8'h5A);
        commit(bc);
        check(bc == WRC && wr_cnt == 1 && shadow[11'h3F0] == 8'h5A,
              "R5 lower half with wp", wr_cnt, 1);
        wp = 1'b0;
        clear_log();
        open_wr(11'h7FF); put(8'hC3);
        commit(bc);
        check(wr_cnt == 1 && shadow[11'h7FF] == 8'hC3, "R5 upper half wp low",
              shadow[11'h7FF], 8'hC3);
    endtask

    task automatic t_empty();
        int bc;
        clear_log();
        open_wr(11'h100);
        commit(bc);
        check(bc == 0, "R8 no busy", bc, 0);
        check(wr_cnt == 0, "R8 no write", wr_cnt, 0);
    endtask

    task automatic t_mask();
        int bc;
        clear_log();
        open_wr(11'h300); put(8'hE0); put(8'hE1);
        open_wr(11'h308); put(8'h55);
        commit(bc);
        check(wr_cnt == 1, "R7 only new entry", wr_cnt, 1);
        check(hit[11'h300] == 1'b0 && shadow[11'h308] == 8'h55, "R7 mask cleared",
              shadow[11'h308], 8'h55);
    endtask

    task automatic t_restart();
        int bc;
        clear_log();
        open_wr(11'h310); put(8'h01); put(8'h02);
        @(negedge clk); restart_stb = 1'b1;
        @(negedge clk); restart_stb = 1'b0;
        commit(bc);
        check(bc == 0, "R9 no busy", bc, 0);
        check(wr_cnt == 0, "R9 discarded", wr_cnt, 0);
    endtask

    task automatic t_busy_ignore();
        int bc;
        clear_log();
        open_wr(11'h320); put(8'h11);
        @(negedge clk); commit_stb = 1'b1;
        @(negedge clk); commit_stb = 1'b0;
        check(busy == 1'b1, "R2 busy next cycle", busy, 1);
        wr_begin = 1'b1; begin_addr = 11'h330;
        @(negedge clk); wr_begin = 1'b0; byte_stb = 1'b1; byte_data = 8'h99;
        @(negedge clk); byte_stb = 1'b0; restart_stb = 1'b1;
        @(negedge clk); restart_stb = 1'b0; commit_stb = 1'b1;
        @(negedge clk); commit_stb = 1'b0;
        repeat (WRC + 4) @(negedge clk);
        check(wr_cnt == 1 && shadow[11'h320] == 8'h11, "R10 commit intact",
              wr_cnt, 1);
        check(hit[11'h330] == 1'b0, "R10 byte ignored", hit[11'h330], 0);
        check(busy == 1'b0, "R10 no second window", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            shadow[i] = '0;
            hit[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_overflow();
        t_wp();
        t_empty();
        t_mask();
        t_restart();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule